// File: doc/BRIEF.md
# Slow-Tick Past and Previous Value Sampler

This block runs on a fast base clock. It watches a data word and a single-cycle tick qualifier. The tick marks the base cycles on which a slower sampling clock has an edge. On every base cycle it presents two views of the data that the slow clock captured.

The first view is the past value. Between ticks it holds the word captured at the most recent tick. On a tick cycle it still shows the word from the tick before, because the current capture lands only at the end of that cycle. The second view is the previous value. It first aligns to the latest tick, which may be the current cycle, and then steps one tick further back. The two views agree on tick cycles and differ on the cycles between ticks.

Until enough ticks have been captured, both views return a configurable initial word. A two-bit saturating count of ticks seen lets a checker tell when each view carries real data. Two registers hold the tick-sampled history, a recent and an older slot.

Top module: `slow_past_sampler`

## Requirements
- R1: While reset is high at a rising clock edge, the next cycle shows past_o and prev_o equal to INIT_VAL and depth_o equal to 0. Reset is synchronous and active-high.
- R2: On a cycle with tick_i low, past_o equals the data_i value present on the most recent earlier tick cycle.
- R3: On a cycle with tick_i high, past_o equals the data_i value from the tick before the current one, not the current data_i.
- R4: On a cycle with tick_i high, prev_o equals past_o in that same cycle.
- R5: On a cycle with tick_i low, prev_o equals the data_i value captured at the second most recent earlier tick.
- R6: past_o is INIT_VAL while depth_o is 0. On non-tick cycles, prev_o is INIT_VAL while depth_o is below 2.
- R7: depth_o rises by one in the cycle after each tick, starting from 0, and stays at 3 once it reaches 3. It is unchanged after non-tick cycles.
- R8: data_i on cycles with tick_i low has no effect on past_o or prev_o in any later cycle.
- R9: For ticks at cycles 2, 5, 8 and 11 after reset, past_o is INIT_VAL for cycles 0 to 2, then shows the cycle-2 word for cycles 3 to 5, the cycle-5 word for cycles 6 to 8, and the cycle-8 word from cycle 9. Over the same cycles prev_o is INIT_VAL for cycles 0 to 4, then shows the cycle-2 word for cycles 5 to 7, the cycle-5 word for cycles 8 to 10, and the cycle-8 word at cycle 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast base clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | DATA_W | Word to be sampled on slow ticks |
| tick_i | input | 1 | High for one base cycle per slow-clock edge |
| past_o | output | DATA_W | Past view: recent slot before this cycle's update |
| prev_o | output | DATA_W | Previous view: aligned to latest tick, then one tick back |
| depth_o | output | 2 | Saturating count of ticks seen since reset |

## Verification
past_o and depth_o are register outputs. A tick shows its effect in the cycle after the edge that ends the tick cycle. prev_o also depends on tick_i within the same cycle, so its tick-cycle value is due in that cycle. The bench changes inputs on the falling edge and samples every output 2 ns later, before the next rising edge. Each check therefore covers the tick_i of the current cycle and the state left by all earlier edges. A dedicated run replays the tick pattern 2, 5, 8, 11 against fixed expected words, and the other scenarios compare each cycle with a history model kept from the requirements.

// File: rtl/past_sampler_pkg.sv
package past_sampler_pkg;
  localparam int DEPTH_W = 2;
  typedef logic [DEPTH_W-1:0] depth_t;
  localparam depth_t DEPTH_MAX = depth_t'((1 << DEPTH_W) - 1);
endpackage

// File: rtl/tick_history.sv
module tick_history #(
  parameter int          DATA_W   = 8,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] recent_o,
  output logic [DATA_W-1:0] older_o
);
  logic [DATA_W-1:0] recent_q;
  logic [DATA_W-1:0] older_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      recent_q <= INIT_VAL;
      older_q  <= INIT_VAL;
    end else if (tick_i) begin
      older_q  <= recent_q;
      recent_q <= data_i;
    end
  end

  assign recent_o = recent_q;
  assign older_o  = older_q;
endmodule

// File: rtl/align_select.sv
module align_select #(
  parameter int DATA_W = 8
) (
  input  logic              tick_i,
  input  logic [DATA_W-1:0] recent_i,
  input  logic [DATA_W-1:0] older_i,
  output logic [DATA_W-1:0] past_o,
  output logic [DATA_W-1:0] prev_o
);
  always_comb begin
    past_o = recent_i;
    prev_o = tick_i ? recent_i : older_i;
  end
endmodule

// File: rtl/tick_depth_counter.sv
module tick_depth_counter
  import past_sampler_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick_i,
  output depth_t depth_o
);
  depth_t cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (tick_i && cnt_q != DEPTH_MAX)
      cnt_q <= cnt_q + depth_t'(1);
  end

  assign depth_o = cnt_q;
endmodule

// File: rtl/slow_past_sampler.sv
module slow_past_sampler
  import past_sampler_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] INIT_VAL = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] past_o,
  output logic [DATA_W-1:0] prev_o,
  output logic [DEPTH_W-1:0] depth_o
);
  logic [DATA_W-1:0] recent_w;
  logic [DATA_W-1:0] older_w;
  depth_t            depth_w;

  tick_history #(
    .DATA_W  (DATA_W),
    .INIT_VAL(INIT_VAL)
  ) u_hist (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .data_i  (data_i),
    .recent_o(recent_w),
    .older_o (older_w)
  );

  align_select #(
    .DATA_W(DATA_W)
  ) u_sel (
    .tick_i  (tick_i),
    .recent_i(recent_w),
    .older_i (older_w),
    .past_o  (past_o),
    .prev_o  (prev_o)
  );

  tick_depth_counter u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .depth_o(depth_w)
  );

  assign depth_o = depth_w;
endmodule

// File: rtl/slow_past_sampler_chk.sv
module slow_past_sampler_chk #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] INIT_VAL = 8'h5A
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] data_i,
  input logic              tick_i,
  input logic [DATA_W-1:0] past_o,
  input logic [DATA_W-1:0] prev_o,
  input logic [1:0]        depth_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (past_o == INIT_VAL && prev_o == INIT_VAL && depth_o == 2'd0)); // R1

  AST_PAST_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(tick_i)) |-> $stable(past_o)); // R2

  AST_PAST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(tick_i)) |-> past_o == $past(data_i)); // R3

  AST_TICK_AGREE: assert property (@(posedge clk) disable iff (rst)
    tick_i |-> prev_o == past_o); // R4

  AST_PREV_STEP: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(tick_i) && !tick_i) |-> prev_o == $past(past_o)); // R5

  AST_INIT_PAST: assert property (@(posedge clk) disable iff (rst)
    (depth_o == 2'd0) |-> past_o == INIT_VAL); // R6

  AST_INIT_PREV: assert property (@(posedge clk) disable iff (rst)
    (depth_o < 2'd2 && !tick_i) |-> prev_o == INIT_VAL); // R6

  AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(tick_i) && $past(depth_o) != 2'd3) |-> depth_o == $past(depth_o) + 2'd1); // R7

  AST_DEPTH_SAT: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(depth_o) == 2'd3) |-> depth_o == 2'd3); // R7

  AST_DEPTH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(tick_i)) |-> $stable(depth_o)); // R7
endmodule

bind slow_past_sampler slow_past_sampler_chk #(
  .DATA_W  (DATA_W),
  .INIT_VAL(INIT_VAL)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .data_i (data_i),
  .tick_i (tick_i),
  .past_o (past_o),
  .prev_o (prev_o),
  .depth_o(depth_o)
);

// File: tb/test_slow_past_sampler.sv
`timescale 1ns/1ps
module test_slow_past_sampler;
  localparam int          W    = 8;
  localparam logic [W-1:0] INIT = 8'h5A;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] data_i = '0;
  logic         tick_i = 1'b0;
  logic [W-1:0] past_o, prev_o;
  logic [1:0]   depth_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model of the tick history, kept from the requirements
  logic [W-1:0] m_recent = INIT;
  logic [W-1:0] m_older  = INIT;
  int           m_depth  = 0;

  always #4 clk = ~clk;

  slow_past_sampler #(.DATA_W(W), .INIT_VAL(INIT)) i_slow_past_sampler (
    .clk(clk), .rst(rst), .data_i(data_i), .tick_i(tick_i),
    .past_o(past_o), .prev_o(prev_o), .depth_o(depth_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic r, input logic t, input logic [W-1:0] d);
    if (r) begin
      m_recent = INIT; m_older = INIT; m_depth = 0;
    end else if (t) begin
      m_older = m_recent; m_recent = d;
      if (m_depth < 3) m_depth++;
    end
  endtask

  // one base cycle: drive on falling edge, check mid-low phase, then advance
  task automatic cyc(input logic [W-1:0] d, input logic t);
    data_i = d; tick_i = t;
    #2;
    if (t) begin
      chk("R3", "past_o on tick", past_o, m_recent);
      chk("R4", "prev_o on tick", prev_o, m_recent);
    end else begin
      chk("R2", "past_o between ticks", past_o, m_recent);
      chk("R5", "prev_o between ticks", prev_o, m_older);
    end
    if (m_depth == 0) chk("R6", "past_o initial", past_o, INIT);
    if (m_depth < 2 && !t) chk("R6", "prev_o initial", prev_o, INIT);
    chk("R7", "depth_o", depth_o, m_depth);
    @(posedge clk);
    model_edge(1'b0, t, d);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick_i = 1'b0; data_i = 8'hEE;
    @(posedge clk);
    model_edge(1'b1, 1'b0, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #2;
    chk("R1", "past_o after reset", past_o, INIT);
    chk("R1", "prev_o after reset", prev_o, INIT);
    chk("R1", "depth_o after reset", depth_o, 0);
    @(negedge clk);
    // R1 mid-run: load history, then reset again
    cyc(8'h11, 1'b1); cyc(8'h22, 1'b1); cyc(8'h33, 1'b0);
    do_reset();
    #2;
    chk("R1", "past_o after mid-run reset", past_o, INIT);
    chk("R1", "prev_o after mid-run reset", prev_o, INIT);
    chk("R1", "depth_o after mid-run reset", depth_o, 0);
    @(negedge clk);
  endtask

  // R9: ticks at cycles 2, 5, 8, 11 with fixed expected words
  task automatic t_pattern();
    logic [W-1:0] ep, ev;
    do_reset();
    for (int k = 0; k < 12; k++) begin
      logic t;
      t = (k == 2 || k == 5 || k == 8 || k == 11);
      if (k <= 2) ep = INIT; else if (k <= 5) ep = 8'hA2; else if (k <= 8) ep = 8'hA5; else ep = 8'hA8;
      if (k <= 4) ev = INIT; else if (k <= 7) ev = 8'hA2; else if (k <= 10) ev = 8'hA5; else ev = 8'hA8;
      data_i = W'(8'hA0 + k); tick_i = t;
      #2;
      chk("R9", $sformatf("past_o cycle %0d", k), past_o, ep);
      chk("R9", $sformatf("prev_o cycle %0d", k), prev_o, ev);
      @(posedge clk);
      model_edge(1'b0, t, W'(8'hA0 + k));
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  // back-to-back ticks: every cycle is a tick
  task automatic t_dense();
    do_reset();
    for (int k = 0; k < 6; k++) cyc(W'(8'h30 + k), 1'b1);
    for (int k = 0; k < 3; k++) cyc(8'h00, 1'b0);
  endtask

  // R8: non-tick data never reaches the outputs
  task automatic t_ignore();
    do_reset();
    cyc(8'h71, 1'b1);
    cyc(8'h72, 1'b1);
    for (int k = 0; k < 5; k++) cyc(W'(8'hC0 + 17 * k), 1'b0);
    data_i = 8'hFF; tick_i = 1'b0; #2;
    chk("R8", "past_o keeps tick word", past_o, 8'h72);
    chk("R8", "prev_o keeps older tick word", prev_o, 8'h71);
    @(negedge clk);
    data_i = 8'h00; tick_i = 1'b1; #2;
    chk("R8", "past_o on next tick", past_o, 8'h72);
    @(posedge clk); model_edge(1'b0, 1'b1, 8'h00); @(negedge clk);
    tick_i = 1'b0;
  endtask

  // R7: saturation of the tick count, with sparse and irregular gaps
  task automatic t_saturate();
    do_reset();
    for (int k = 0; k < 7; k++) begin
      cyc(W'(8'h50 + k), 1'b1);
      for (int g = 0; g < k % 3; g++) cyc(8'h99, 1'b0);
    end
    #2;
    chk("R7", "depth_o saturated", depth_o, 3);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pattern();
    t_dense();
    t_ignore();
    t_saturate();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule